// File: doc/BRIEF.md
# Capture/Compare Timer with Interrupt Flags

A 16-bit free-running up-counter shared by two channels. Each channel can latch the counter value when its input shows a chosen edge, act on its pin when the counter reaches a programmed value, or generate an edge-aligned pulse-width-modulated wave. The block keeps sticky event flags: one for the counter wrap and one per channel. A per-flag local enable decides whether each flag contributes to one active-high interrupt request.

Software reaches the block through a small synchronous register port. A write takes effect on the clock edge where `regWe` is high. Reads are combinational from `regAddr`. The counter runs only while its run bit is set. A modulo register sets the terminal count. Flags are cleared by writing ones to the status register.

Top module: `capcmp_timer`

## Requirements
- R1: After reset every register reads 0, the counter is stopped, `irq` is low, and every channel is in capture mode with `chOe` and `chOut` low.
- R2: While the run bit (address 0 bit 0) is 1, the counter steps once per clock from 0 up to the terminal count and then to 0. The terminal count is the modulo register (address 1), or 0xFFFF when that register is 0. With the run bit at 0 the counter holds. A write to address 2 forces it to 0. Address 2 reads the counter.
- R3: The overflow flag (address 3 bit 0) sets on the clock edge where the running counter moves from the terminal count to 0.
- R4: In capture mode (channel config bits [1:0] = 00), the edge field (bits [3:2]) selects the edges that trigger a capture: 01 rising, 10 falling, 11 both, 00 none. The input passes through two synchronizing flops. The flag (address 3 bit 1+n) and the capture of the counter into the value register happen on the third clock edge after the input changes. The captured value is the count present just before that edge.
- R5: In compare mode (01) or PWM mode (10), a channel flag sets on the edge where the running counter equals the channel value register.
- R6: In compare mode, a match acts on the pin according to the edge field: 01 toggles it, 10 drives it low, 11 drives it high. With field 00 the pin is released (`chOe` = 0). With any other field value `chOe` = 1.
- R7: In PWM mode with a nonzero edge field, the pin is driven and reads high exactly while the counter is below the value register. A value of 0 gives a constant low. A value above the terminal count gives a constant high.
- R8: Flags read back whether or not they are enabled. `irq` is high exactly when some flag is set together with its enable: overflow enable at address 0 bit 1, channel enable at channel config bit 4.
- R9: Writing 1 to a status bit clears that flag, and writing 0 leaves it unchanged. If an event and a clear fall in the same cycle, the flag stays set.
- R10: Channel n's config is at address 4+n, holding bits [4:0], with the upper bits reading 0. Its value register is at address 6+n and is fully writable and readable. The modulo register holds 16 bits. Address 0 reads back its two bits.
- R11: In capture mode the pin is released (`chOe` = 0) whatever the edge field holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address |
| regWdata | input | 16 | Write data |
| regRdata | output | 16 | Read data for `regAddr` |
| chIn | input | 2 | Capture inputs, one per channel |
| chOut | output | 2 | Channel pin values |
| chOe | output | 2 | Channel pin drive enables |
| irq | output | 1 | Interrupt request, active high |

## Verification
Some rules are checked on every cycle. A wrap is always followed by a zero count and a set overflow flag. A set flag survives any cycle without a matching clear. A capture always latches the preceding count. A capture-mode channel never drives its pin. The interrupt stays low when no flag is set. The bench scenarios cover what needs a chosen history: edge selection seen through the synchronizer delay, event-versus-clear collisions, the full 16-bit wrap with a zero modulo, compare pin actions, PWM duty at both extremes, and the register map.

// File: rtl/capcmp_pkg.sv
package capcmp_pkg;
  localparam int CNT_W  = 16;
  localparam int NUM_CH = 2;
  localparam int ADDR_W = $clog2(4 + 2 * NUM_CH);

  typedef enum logic [1:0] {
    MODE_CAP  = 2'b00,
    MODE_CMP  = 2'b01,
    MODE_PWM  = 2'b10,
    MODE_IDLE = 2'b11
  } chMode_e;

  typedef struct packed {
    logic              run;
    logic              cntClear;
    logic [NUM_CH-1:0] valWe;
    logic [CNT_W-1:0]  wdata;
  } tmrStrobe_t;
endpackage

// File: rtl/capcmp_datapath.sv
module capcmp_datapath
  import capcmp_pkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  tmrStrobe_t                    stb,
  input  logic [CNT_W-1:0]              modulo,
  input  logic [NUM_CH-1:0][1:0]        chMode,
  input  logic [NUM_CH-1:0][1:0]        chLevel,
  input  logic [NUM_CH-1:0]             chIn,
  output logic [CNT_W-1:0]              count,
  output logic [NUM_CH-1:0][CNT_W-1:0]  chValue,
  output logic                          ovfEvt,
  output logic [NUM_CH-1:0]             chEvt,
  output logic [NUM_CH-1:0]             chOut,
  output logic [NUM_CH-1:0]             chOe
);
  logic [CNT_W-1:0] cntQ, cntNext, termValue;
  logic             wrap;

  assign termValue = (modulo == '0) ? '1 : modulo;
  assign wrap      = stb.run && (cntQ == termValue);
  assign ovfEvt    = wrap;
  assign count     = cntQ;

  always_comb begin
    if (stb.cntClear)  cntNext = '0;
    else if (!stb.run) cntNext = cntQ;
    else if (wrap)     cntNext = '0;
    else               cntNext = cntQ + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cntQ <= '0;
    else       cntQ <= cntNext;
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : gChan
    chMode_e          mode;
    logic [2:0]       syncQ;   // [0] first stage, [1] second stage, [2] previous
    logic             rise, fall, capHit, match, cmpHit, outQ;
    logic [CNT_W-1:0] valQ;

    assign mode   = chMode_e'(chMode[g]);
    assign rise   = syncQ[1] & ~syncQ[2];
    assign fall   = ~syncQ[1] & syncQ[2];
    assign capHit = (mode == MODE_CAP) &&
                    ((chLevel[g][0] && rise) || (chLevel[g][1] && fall));
    assign match  = stb.run && (cntQ == valQ);
    assign cmpHit = ((mode == MODE_CMP) || (mode == MODE_PWM)) && match;

    assign chEvt[g]   = capHit | cmpHit;
    assign chOe[g]    = ((mode == MODE_CMP) || (mode == MODE_PWM)) && (chLevel[g] != 2'b00);
    assign chOut[g]   = outQ & chOe[g];
    assign chValue[g] = valQ;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncQ <= '0;
        valQ  <= '0;
        outQ  <= 1'b0;
      end else begin
        syncQ <= {syncQ[1:0], chIn[g]};
        if (capHit)            valQ <= cntQ;
        else if (stb.valWe[g]) valQ <= stb.wdata;
        case (mode)
          MODE_CMP: begin
            if (match) begin
              case (chLevel[g])
                2'b01:   outQ <= ~outQ;
                2'b10:   outQ <= 1'b0;
                2'b11:   outQ <= 1'b1;
                default: outQ <= outQ;
              endcase
            end
          end
          MODE_PWM: outQ <= (cntNext < valQ);
          default:  outQ <= 1'b0;
        endcase
      end
    end
  end
endmodule

// File: rtl/capcmp_ctrl.sv
module capcmp_ctrl
  import capcmp_pkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          regWe,
  input  logic [ADDR_W-1:0]             regAddr,
  input  logic [CNT_W-1:0]              regWdata,
  output logic [CNT_W-1:0]              regRdata,
  input  logic [CNT_W-1:0]              count,
  input  logic [NUM_CH-1:0][CNT_W-1:0]  chValue,
  input  logic                          ovfEvt,
  input  logic [NUM_CH-1:0]             chEvt,
  output tmrStrobe_t                    stb,
  output logic [CNT_W-1:0]              modulo,
  output logic [NUM_CH-1:0][1:0]        chMode,
  output logic [NUM_CH-1:0][1:0]        chLevel,
  output logic [NUM_CH:0]               flags,
  output logic                          irq
);
  localparam int A_CTRL = 0;
  localparam int A_MOD  = 1;
  localparam int A_CNT  = 2;
  localparam int A_STAT = 3;
  localparam int A_CFG0 = 4;
  localparam int A_VAL0 = 4 + NUM_CH;

  logic                   runQ, ovfIeQ;
  logic [CNT_W-1:0]       modQ;
  logic [NUM_CH-1:0][1:0] modeQ, lvlQ;
  logic [NUM_CH-1:0]      ieQ;
  logic [NUM_CH:0]        flagQ, flagNext, clrMask;

  always_comb begin
    clrMask = '0;
    if (regWe && regAddr == ADDR_W'(A_STAT)) clrMask = regWdata[NUM_CH:0];
    flagNext = (flagQ & ~clrMask) | {chEvt, ovfEvt};
  end

  always_comb begin
    stb.run      = runQ;
    stb.cntClear = regWe && (regAddr == ADDR_W'(A_CNT));
    stb.wdata    = regWdata;
    for (int i = 0; i < NUM_CH; i++)
      stb.valWe[i] = regWe && (regAddr == ADDR_W'(A_VAL0 + i));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runQ   <= 1'b0;
      ovfIeQ <= 1'b0;
      modQ   <= '0;
      modeQ  <= '0;
      lvlQ   <= '0;
      ieQ    <= '0;
      flagQ  <= '0;
    end else begin
      if (regWe && regAddr == ADDR_W'(A_CTRL)) begin
        runQ   <= regWdata[0];
        ovfIeQ <= regWdata[1];
      end
      if (regWe && regAddr == ADDR_W'(A_MOD)) modQ <= regWdata;
      for (int i = 0; i < NUM_CH; i++) begin
        if (regWe && regAddr == ADDR_W'(A_CFG0 + i)) begin
          modeQ[i] <= regWdata[1:0];
          lvlQ[i]  <= regWdata[3:2];
          ieQ[i]   <= regWdata[4];
        end
      end
      flagQ <= flagNext;
    end
  end

  always_comb begin
    regRdata = '0;
    if (regAddr == ADDR_W'(A_CTRL)) regRdata[1:0]        = {ovfIeQ, runQ};
    if (regAddr == ADDR_W'(A_MOD))  regRdata             = modQ;
    if (regAddr == ADDR_W'(A_CNT))  regRdata             = count;
    if (regAddr == ADDR_W'(A_STAT)) regRdata[NUM_CH:0]   = flagQ;
    for (int i = 0; i < NUM_CH; i++) begin
      if (regAddr == ADDR_W'(A_CFG0 + i)) regRdata[4:0] = {ieQ[i], lvlQ[i], modeQ[i]};
      if (regAddr == ADDR_W'(A_VAL0 + i)) regRdata      = chValue[i];
    end
  end

  assign modulo  = modQ;
  assign chMode  = modeQ;
  assign chLevel = lvlQ;
  assign flags   = flagQ;
  assign irq     = |(flagQ & {ieQ, ovfIeQ});
endmodule

// File: rtl/capcmp_timer.sv
module capcmp_timer
  import capcmp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [CNT_W-1:0]  regWdata,
  output logic [CNT_W-1:0]  regRdata,
  input  logic [NUM_CH-1:0] chIn,
  output logic [NUM_CH-1:0] chOut,
  output logic [NUM_CH-1:0] chOe,
  output logic              irq
);
  tmrStrobe_t                   stb;
  logic [CNT_W-1:0]             modulo, cntValue;
  logic [NUM_CH-1:0][1:0]       chMode, chLevel;
  logic [NUM_CH-1:0][CNT_W-1:0] chValue;
  logic                         ovfEvt;
  logic [NUM_CH-1:0]            chEvt;
  logic [NUM_CH:0]              flags;

  capcmp_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .count(cntValue),
    .chValue(chValue), .ovfEvt(ovfEvt), .chEvt(chEvt), .stb(stb),
    .modulo(modulo), .chMode(chMode), .chLevel(chLevel),
    .flags(flags), .irq(irq)
  );

  capcmp_datapath uData (
    .clk(clk), .rstN(rstN), .stb(stb), .modulo(modulo),
    .chMode(chMode), .chLevel(chLevel), .chIn(chIn), .count(cntValue),
    .chValue(chValue), .ovfEvt(ovfEvt), .chEvt(chEvt),
    .chOut(chOut), .chOe(chOe)
  );
endmodule

// File: rtl/capcmp_timer_chk.sv
module capcmp_timer_chk
  import capcmp_pkg::*;
(
  input logic                          clk,
  input logic                          rstN,
  input logic                          regWe,
  input logic [ADDR_W-1:0]             regAddr,
  input logic [CNT_W-1:0]              regWdata,
  input logic [CNT_W-1:0]              cntValue,
  input logic [NUM_CH-1:0][CNT_W-1:0]  chValue,
  input logic [NUM_CH-1:0][1:0]        chMode,
  input logic                          ovfEvt,
  input logic [NUM_CH-1:0]             chEvt,
  input logic [NUM_CH:0]               flags,
  input logic [NUM_CH-1:0]             chOe,
  input logic                          irq
);
  logic ovfClr;
  assign ovfClr = regWe && (regAddr == ADDR_W'(3)) && regWdata[0];

  // R3
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    ovfEvt |=> (cntValue == '0));

  // R9
  evt_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    ovfEvt |=> flags[0]);

  // R9
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flags[0] && !ovfClr) |=> flags[0]);

  // R8
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flags == '0) |-> !irq);

  for (genvar i = 0; i < NUM_CH; i++) begin : gChk
    // R11
    cap_release_chk: assert property (@(posedge clk) disable iff (!rstN)
      (chMode[i] == 2'b00) |-> !chOe[i]);

    // R4
    cap_latch_chk: assert property (@(posedge clk) disable iff (!rstN)
      (chEvt[i] && chMode[i] == 2'b00) |=> (chValue[i] == $past(cntValue)));
  end
endmodule

bind capcmp_timer capcmp_timer_chk uChk (
  .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
  .regWdata(regWdata), .cntValue(cntValue), .chValue(chValue),
  .chMode(chMode), .ovfEvt(ovfEvt), .chEvt(chEvt), .flags(flags),
  .chOe(chOe), .irq(irq)
);

// File: tb/tb_capcmp_timer.sv
module tb_capcmp_timer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [15:0] regWdata = '0;
  logic [15:0] regRdata;
  logic [1:0]  chIn = '0;
  logic [1:0]  chOut, chOe;
  logic        irq;

  int nVec = 0;
  int nFail = 0;

  localparam logic [2:0] A_CTRL = 3'd0, A_MOD = 3'd1, A_CNT = 3'd2, A_STAT = 3'd3,
                         A_CFG0 = 3'd4, A_CFG1 = 3'd5, A_VAL0 = 3'd6, A_VAL1 = 3'd7;

  // {write, addr, data, expected read}
  localparam logic [35:0] VEC [17] = '{
    {1'b1, 3'd1, 16'h1234, 16'h0000}, {1'b0, 3'd1, 16'h0000, 16'h1234},
    {1'b1, 3'd4, 16'h001D, 16'h0000}, {1'b0, 3'd4, 16'h0000, 16'h001D},
    {1'b1, 3'd5, 16'hFFE6, 16'h0000}, {1'b0, 3'd5, 16'h0000, 16'h0006},
    {1'b1, 3'd6, 16'hBEEF, 16'h0000}, {1'b0, 3'd6, 16'h0000, 16'hBEEF},
    {1'b1, 3'd7, 16'h0102, 16'h0000}, {1'b0, 3'd7, 16'h0000, 16'h0102},
    {1'b1, 3'd0, 16'hFFFE, 16'h0000}, {1'b0, 3'd0, 16'h0000, 16'h0002},
    {1'b0, 3'd2, 16'h0000, 16'h0000}, {1'b1, 3'd0, 16'h0000, 16'h0000},
    {1'b1, 3'd4, 16'h0000, 16'h0000}, {1'b1, 3'd5, 16'h0000, 16'h0000},
    {1'b0, 3'd3, 16'h0000, 16'h0000}
  };

  capcmp_timer dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .chIn(chIn),
    .chOut(chOut), .chOe(chOe), .irq(irq)
  );

  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nVec++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // called at a negedge; returns at the next negedge
  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    regAddr = a; regWdata = d; regWe = 1'b1;
    @(posedge clk); @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    regAddr = a; #1; d = regRdata;
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    nFail++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    logic [15:0] d, c;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), d);
      chk("R1 register after reset", d, 16'h0);
    end
    chk("R1 irq", {15'b0, irq}, 16'h0);
    chk("R1 chOe", {14'b0, chOe}, 16'h0);
    chk("R1 chOut", {14'b0, chOut}, 16'h0);

    // R10: register map vectors
    for (int i = 0; i < 17; i++) begin
      if (VEC[i][35]) wr(VEC[i][34:32], VEC[i][31:16]);
      else begin
        rd(VEC[i][34:32], d);
        chk("R10 readback", d, VEC[i][15:0]);
      end
    end

    // R2 R3 R8: overflow with modulo 3
    wr(A_MOD, 16'd3);
    wr(A_CTRL, 16'h1);
    tick(3);
    rd(A_CNT, d);  chk("R2 count at terminal", d, 16'd3);
    rd(A_STAT, d); chk("R3 no flag before wrap", d, 16'h0);
    tick(1);
    rd(A_CNT, d);  chk("R2 wrap to zero", d, 16'd0);
    rd(A_STAT, d); chk("R3 flag at wrap", d, 16'h1);
    chk("R8 flag polled without irq", {15'b0, irq}, 16'h0);
    wr(A_CTRL, 16'h2);
    rd(A_CNT, d);  chk("R2 held after stop", d, 16'd1);
    tick(2);
    rd(A_CNT, d);  chk("R2 still held", d, 16'd1);
    chk("R8 irq with enable", {15'b0, irq}, 16'h1);
    wr(A_STAT, 16'h0);
    rd(A_STAT, d); chk("R9 write zero keeps flag", d, 16'h1);
    wr(A_STAT, 16'h1);
    rd(A_STAT, d); chk("R9 write one clears", d, 16'h0);
    chk("R8 irq drops", {15'b0, irq}, 16'h0);

    // R9: event and clear in the same cycle
    wr(A_CNT, 16'h0);
    rd(A_CNT, d);  chk("R2 count clear", d, 16'h0);
    wr(A_CTRL, 16'h3);
    tick(3);
    wr(A_STAT, 16'h1);
    rd(A_STAT, d); chk("R9 event wins over clear", d, 16'h1);
    wr(A_CTRL, 16'h0);
    wr(A_STAT, 16'h7);

    // R2: modulo 0 counts the full range
    wr(A_CNT, 16'h0);
    wr(A_MOD, 16'h0);
    wr(A_CTRL, 16'h1);
    tick(65535);
    rd(A_CNT, d);  chk("R2 full count top", d, 16'hFFFF);
    rd(A_STAT, d); chk("R3 no flag at top", d, 16'h0);
    tick(1);
    rd(A_CNT, d);  chk("R2 full count wrap", d, 16'h0);
    rd(A_STAT, d); chk("R3 flag after full wrap", d, 16'h1);
    wr(A_STAT, 16'h7);

    // R4 R11: capture on channel 0, rising edge, enabled
    wr(A_CFG0, 16'h0014);
    chk("R11 capture releases pin", {14'b0, chOe}, 16'h0);
    rd(A_CNT, c);
    chIn[0] = 1'b1;
    tick(2);
    rd(A_STAT, d); chk("R4 no flag before sync delay", d, 16'h0);
    tick(1);
    rd(A_STAT, d); chk("R4 rising flag", d, 16'h2);
    rd(A_VAL0, d); chk("R4 captured count", d, c + 16'd2);
    chk("R8 channel irq", {15'b0, irq}, 16'h1);
    wr(A_STAT, 16'h2);
    c = c + 16'd2;
    chIn[0] = 1'b0;
    tick(4);
    rd(A_STAT, d); chk("R4 falling ignored on rising select", d, 16'h0);
    rd(A_VAL0, d); chk("R4 value untouched", d, c);

    wr(A_CFG0, 16'h001C);
    rd(A_CNT, c);
    chIn[0] = 1'b1;
    tick(3);
    rd(A_STAT, d); chk("R4 both edges rise", d, 16'h2);
    rd(A_VAL0, d); chk("R4 both edges rise value", d, c + 16'd2);
    wr(A_STAT, 16'h2);
    rd(A_CNT, c);
    chIn[0] = 1'b0;
    tick(3);
    rd(A_STAT, d); chk("R4 both edges fall", d, 16'h2);
    rd(A_VAL0, d); chk("R4 both edges fall value", d, c + 16'd2);
    wr(A_STAT, 16'h2);

    wr(A_CFG0, 16'h001C & 16'h0010);
    chIn[0] = 1'b1; tick(4);
    chIn[0] = 1'b0; tick(4);
    rd(A_STAT, d); chk("R4 disabled edge field", d, 16'h0);
    wr(A_CTRL, 16'h0);
    wr(A_STAT, 16'h7);
    wr(A_CFG0, 16'h0);

    // R5 R6: compare on channel 1, set on match
    wr(A_CNT, 16'h0);
    wr(A_VAL1, 16'd5);
    wr(A_CFG1, 16'h001D);
    chk("R6 compare drives pin", {14'b0, chOe}, 16'h2);
    chk("R6 pin low before match", {14'b0, chOut}, 16'h0);
    wr(A_CTRL, 16'h1);
    tick(5);
    rd(A_STAT, d); chk("R5 no flag before match", d, 16'h0);
    tick(1);
    rd(A_STAT, d); chk("R5 flag on match", d, 16'h4);
    chk("R6 set on match", {14'b0, chOut}, 16'h2);
    chk("R8 irq from channel 1", {15'b0, irq}, 16'h1);
    wr(A_CTRL, 16'h0);
    wr(A_STAT, 16'h7);
    wr(A_CFG1, 16'h0015);
    wr(A_CNT, 16'h0);
    wr(A_CTRL, 16'h1);
    tick(6);
    chk("R6 toggle on match", {14'b0, chOut}, 16'h0);
    wr(A_CFG1, 16'h0011);
    chk("R6 field 00 releases pin", {14'b0, chOe}, 16'h0);
    wr(A_CTRL, 16'h0);
    wr(A_STAT, 16'h7);
    wr(A_CFG1, 16'h0);

    // R7: PWM on channel 0, modulo 4
    wr(A_CNT, 16'h0);
    wr(A_MOD, 16'd4);
    wr(A_VAL0, 16'd2);
    wr(A_CFG0, 16'h0006);
    wr(A_CTRL, 16'h1);
    for (int i = 0; i < 12; i++) begin
      tick(1);
      rd(A_CNT, c);
      chk("R7 duty follows count", {15'b0, chOut[0]}, {15'b0, (c < 16'd2)});
    end
    chk("R7 pin driven", {15'b0, chOe[0]}, 16'h1);
    rd(A_STAT, d); chk("R5 PWM match flag", d & 16'h2, 16'h2);
    wr(A_VAL0, 16'd0);
    for (int i = 0; i < 8; i++) begin
      tick(1);
      chk("R7 zero duty", {15'b0, chOut[0]}, 16'h0);
    end
    wr(A_VAL0, 16'd7);
    for (int i = 0; i < 8; i++) begin
      tick(1);
      chk("R7 full duty", {15'b0, chOut[0]}, 16'h1);
    end

    finishRun();
  end
endmodule